// File: doc/BRIEF.md
# Push-Side Write Interface Controller

This controller connects a producing processing unit to a shared token buffer that lives behind a bus with a single owner at a time. The producer first opens a connection. It then pushes tokens one at a time and finally closes the connection. Each push hands over one data word. The controller copies that word into its own holding register at once, before any synchronization step takes place.

Once a token is held, the controller waits until the buffer reports free room. It then raises a bus request and holds it until the arbiter grants the bus. While it owns the bus, it writes the held token into global memory at a write pointer that wraps around the buffer depth. It then drops the bus request and pulses a one-cycle data signal, which the buffer's counter uses to count one more available token. Only after all of that does the producer receive its push acknowledge. The bus arbiter and the buffer storage are outside this block.

Top module: `push_wr_ctrl`

## Requirements
- R1: During and directly after a synchronous reset, all outputs (open_ack, close_ack, push_ack, bus_req, mem_we, data_signal) are low, the connection is closed and mem_addr is 0.
- R2: While the connection is closed, open_req opens it and gives a one-cycle open_ack in the cycle after open_req is sampled. Pushes made while the connection is closed cause no bus request, no write and no acknowledge.
- R3: While the connection is open and no push is in flight, close_req closes it and gives a one-cycle close_ack in the following cycle. close_req wins over a push_valid sampled in the same cycle. After the close, pushes are ignored.
- R4: push_data is captured on the clock edge that accepts push_valid. Later changes of push_data do not alter the word written to memory.
- R5: bus_req stays low while room_count is zero. A claim starts only on an edge where room_count is non-zero.
- R6: bus_req is held high without any memory write until bus_gnt is sampled high. The write takes place in the cycle after that grant.
- R7: The store is a single mem_we cycle with bus_req still high, mem_addr at the write pointer and mem_wdata holding the captured token. bus_req is low in the very next cycle.
- R8: Exactly one data_signal pulse of one cycle follows each store, in the cycle directly after mem_we.
- R9: push_ack is a one-cycle pulse in the cycle after data_signal. push_valid seen while a push is in flight is ignored.
- R10: The write pointer starts at 0, advances by one per store and wraps from DEPTH-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| open_req | input | 1 | Request to open the connection |
| open_ack | output | 1 | One-cycle open acknowledge |
| close_req | input | 1 | Request to close the connection |
| close_ack | output | 1 | One-cycle close acknowledge |
| push_valid | input | 1 | Producer offers a token |
| push_data | input | DATA_W | Token offered by the producer |
| push_ack | output | 1 | One-cycle push completion |
| room_count | input | CNT_W | Free slots in the shared buffer |
| bus_req | output | 1 | Bus claim, held until the store is done |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_we | output | 1 | Global memory write strobe |
| mem_addr | output | AW | Global memory write address |
| mem_wdata | output | DATA_W | Global memory write data |
| data_signal | output | 1 | One-cycle increment for the buffer's data count |

## Verification
The bench builds the controller with DEPTH = 5 and DATA_W = 12. A depth that is not a power of two shows whether the pointer wraps by comparing against DEPTH-1 rather than by letting bits overflow, and six pushes carry it through that wrap. Room stalls and grant stalls of several lengths, including zero, move the store relative to the push edge. The push data is changed right after each accepted push, and pushes are offered while the connection is closed and while a push is in flight.

// File: rtl/push_wr_pkg.sv
package push_wr_pkg;
  typedef enum logic [3:0] {
    ST_CLOSED,
    ST_OPN_ACK,
    ST_OPEN,
    ST_CLS_ACK,
    ST_ROOM,
    ST_CLAIM,
    ST_STORE,
    ST_SIGNAL,
    ST_ACK
  } wr_state_t;
endpackage

// File: rtl/push_wr_hold.sv
module push_wr_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/push_wr_ptr.sv
module push_wr_ptr #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [AW-1:0] ptr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + AW'(1);
  end
endmodule

// File: rtl/push_wr_fsm.sv
module push_wr_fsm
  import push_wr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_req,
  input  logic             close_req,
  input  logic             push_valid,
  input  logic [CNT_W-1:0] room_count,
  input  logic             bus_gnt,
  output logic             accept,
  output logic             open_ack,
  output logic             close_ack,
  output logic             push_ack,
  output logic             bus_req,
  output logic             mem_we,
  output logic             data_signal
);
  wr_state_t state, state_nxt;

  always_comb begin
    state_nxt = state;
    accept    = 1'b0;
    case (state)
      ST_CLOSED:  if (open_req) state_nxt = ST_OPN_ACK;
      ST_OPN_ACK: state_nxt = ST_OPEN;
      ST_OPEN: begin
        if (close_req) state_nxt = ST_CLS_ACK;
        else if (push_valid) begin
          state_nxt = ST_ROOM;
          accept    = 1'b1;
        end
      end
      ST_CLS_ACK: state_nxt = ST_CLOSED;
      ST_ROOM:    if (room_count != '0) state_nxt = ST_CLAIM;
      ST_CLAIM:   if (bus_gnt) state_nxt = ST_STORE;
      ST_STORE:   state_nxt = ST_SIGNAL;
      ST_SIGNAL:  state_nxt = ST_ACK;
      ST_ACK:     state_nxt = ST_OPEN;
      default:    state_nxt = ST_CLOSED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_CLOSED;
      open_ack    <= 1'b0;
      close_ack   <= 1'b0;
      push_ack    <= 1'b0;
      bus_req     <= 1'b0;
      mem_we      <= 1'b0;
      data_signal <= 1'b0;
    end else begin
      state       <= state_nxt;
      open_ack    <= (state_nxt == ST_OPN_ACK);
      close_ack   <= (state_nxt == ST_CLS_ACK);
      push_ack    <= (state_nxt == ST_ACK);
      bus_req     <= (state_nxt == ST_CLAIM) || (state_nxt == ST_STORE);
      mem_we      <= (state_nxt == ST_STORE);
      data_signal <= (state_nxt == ST_SIGNAL);
    end
  end
endmodule

// File: rtl/push_wr_ctrl.sv
module push_wr_ctrl #(
  parameter  int DATA_W = 16,
  parameter  int DEPTH  = 8,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              open_req,
  output logic              open_ack,
  input  logic              close_req,
  output logic              close_ack,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ack,
  input  logic [CNT_W-1:0]  room_count,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              data_signal
);
  logic accept;

  push_wr_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst),
    .open_req(open_req), .close_req(close_req), .push_valid(push_valid),
    .room_count(room_count), .bus_gnt(bus_gnt),
    .accept(accept),
    .open_ack(open_ack), .close_ack(close_ack), .push_ack(push_ack),
    .bus_req(bus_req), .mem_we(mem_we), .data_signal(data_signal)
  );

  push_wr_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .load(accept), .din(push_data), .dout(mem_wdata)
  );

  push_wr_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .adv(mem_we), .ptr(mem_addr)
  );
endmodule

// File: rtl/push_wr_chk.sv
module push_wr_chk (
  input logic clk,
  input logic rst,
  input logic open_req,
  input logic open_ack,
  input logic close_ack,
  input logic push_ack,
  input logic room_nz,
  input logic bus_req,
  input logic bus_gnt,
  input logic mem_we,
  input logic data_signal
);
  // R2
  open_ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    open_ack |-> $past(open_req));
  // R5
  room_before_claim_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(room_nz));
  // R6
  write_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (bus_req && $past(bus_gnt)));
  // R7
  release_after_store_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (!bus_req && !mem_we));
  // R8
  signal_after_store_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> data_signal);
  // R8
  signal_single_chk: assert property (@(posedge clk) disable iff (rst)
    data_signal |=> !data_signal);
  // R9
  ack_after_signal_chk: assert property (@(posedge clk) disable iff (rst)
    data_signal |=> push_ack);
  // R3
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({open_ack, close_ack, push_ack, data_signal, mem_we}));
endmodule

bind push_wr_ctrl push_wr_chk u_chk (
  .clk(clk), .rst(rst), .open_req(open_req), .open_ack(open_ack),
  .close_ack(close_ack), .push_ack(push_ack), .room_nz(room_count != '0),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_we(mem_we),
  .data_signal(data_signal)
);

// File: tb/test_push_wr_ctrl.sv
module test_push_wr_ctrl;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 12;
  localparam int DEPTH  = 5;
  localparam int AW     = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic open_req = 1'b0, close_req = 1'b0, push_valid = 1'b0, bus_gnt = 1'b0;
  logic [DATA_W-1:0] push_data = '0;
  logic [CNT_W-1:0]  room_count = '0;
  logic open_ack, close_ack, push_ack, bus_req, mem_we, data_signal;
  logic [AW-1:0]     mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  int vectors = 0, fails = 0, sig_count = 0, exp_sig = 0;
  int exp_ptr = 0;
  bit done = 1'b0;
  logic [AW+DATA_W-1:0] sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  push_wr_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_push_wr_ctrl (
    .clk(clk), .rst(rst), .open_req(open_req), .open_ack(open_ack),
    .close_req(close_req), .close_ack(close_ack), .push_valid(push_valid),
    .push_data(push_data), .push_ack(push_ack), .room_count(room_count),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .data_signal(data_signal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: every write pops the scoreboard (R4, R7, R10)
  always @(negedge clk) begin
    if (!rst && data_signal) sig_count++;
    if (!rst && mem_we) begin
      if (sb_q.size() == 0) chk("R9 unexpected write", 32'(mem_addr), 32'hFFFF);
      else begin
        logic [AW+DATA_W-1:0] e;
        e = sb_q.pop_front();
        chk("R10 write address", 32'(mem_addr), 32'(e[AW+DATA_W-1:DATA_W]));
        chk("R4 write data", 32'(mem_wdata), 32'(e[DATA_W-1:0]));
      end
    end
  end

  task automatic idle_check(input string req);
    chk({req, " idle outputs"},
        {26'd0, open_ack, close_ack, push_ack, bus_req, mem_we, data_signal}, 32'd0);
  endtask

  task automatic do_open();
    open_req = 1'b1;
    @(negedge clk); open_req = 1'b0;
    chk("R2 open_ack pulse", 32'(open_ack), 32'd1);
    @(negedge clk);
    chk("R2 open_ack single", 32'(open_ack), 32'd0);
  endtask

  task automatic do_close();
    close_req = 1'b1;
    @(negedge clk); close_req = 1'b0;
    chk("R3 close_ack pulse", 32'(close_ack), 32'd1);
    @(negedge clk);
    chk("R3 close_ack single", 32'(close_ack), 32'd0);
  endtask

  task automatic do_push(input logic [DATA_W-1:0] d, input int rwait, input int gwait,
                         input bit noise);
    push_valid = 1'b1; push_data = d; room_count = '0;
    sb_q.push_back({AW'(exp_ptr), d});
    exp_ptr = (exp_ptr + 1) % DEPTH;
    exp_sig++;
    @(negedge clk);
    push_valid = noise; push_data = ~d;   // R4 and R9: data change, extra pushes
    for (int i = 0; i < rwait; i++) begin
      chk("R5 no claim without room", 32'(bus_req), 32'd0);
      @(negedge clk);
    end
    room_count = CNT_W'(2);
    @(negedge clk);
    for (int i = 0; i <= gwait; i++) begin
      chk("R6 claim held", 32'(bus_req), 32'd1);
      chk("R6 no write before grant", 32'(mem_we), 32'd0);
      if (i == gwait) bus_gnt = 1'b1;
      @(negedge clk);
    end
    bus_gnt = 1'b0;
    chk("R7 store strobe", 32'(mem_we), 32'd1);
    chk("R7 bus owned at store", 32'(bus_req), 32'd1);
    @(negedge clk);
    push_valid = 1'b0;
    chk("R7 bus released", 32'(bus_req), 32'd0);
    chk("R8 data signal", 32'(data_signal), 32'd1);
    chk("R9 no early ack", 32'(push_ack), 32'd0);
    @(negedge clk);
    chk("R9 push ack", 32'(push_ack), 32'd1);
    chk("R8 data signal single", 32'(data_signal), 32'd0);
    @(negedge clk);
    idle_check("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idle_check("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    idle_check("R1 after reset");
    chk("R1 address", 32'(mem_addr), 32'd0);
    // R2: pushes while closed are ignored
    push_valid = 1'b1; push_data = 12'h0AA; room_count = CNT_W'(3); bus_gnt = 1'b1;
    repeat (3) begin
      @(negedge clk);
      idle_check("R2 closed push");
    end
    push_valid = 1'b0; bus_gnt = 1'b0;
    do_open();
    do_push(12'h123, 0, 0, 1'b0);
    do_push(12'h456, 3, 0, 1'b1);
    do_push(12'h789, 0, 4, 1'b0);
    do_push(12'hABC, 2, 2, 1'b1);
    do_push(12'hDEF, 1, 1, 1'b0);
    do_push(12'h5A5, 0, 0, 1'b0);   // R10 wraps to address 0
    chk("R10 address wrapped", 32'(mem_addr), 32'd1);
    // R3: close wins over a push in the same cycle
    push_valid = 1'b1; push_data = 12'h0FF;
    do_close();
    room_count = CNT_W'(3); bus_gnt = 1'b1;
    repeat (3) begin
      @(negedge clk);
      idle_check("R3 push after close");
    end
    push_valid = 1'b0; bus_gnt = 1'b0;
    chk("R8 one signal per push", 32'(sig_count), 32'(exp_sig));
    chk("R9 scoreboard drained", 32'(sb_q.size()), 32'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule